// File: doc/BRIEF.md
# Shadow-Buffered Single-Channel PWM Generator

This block produces one pulse-width-modulated output from a small word-addressed register file. A prescaler turns the system clock into counting ticks. A counter runs through one period of ticks, and the output sits at the programmed active level while the count is below the duty value. It takes the opposite level for the rest of the period. When the channel is off or has stopped, the output rests at a separately programmed idle level. The channel runs either continuously or for exactly one period.

Period, duty and polarity are double-buffered. Writes land in a staging copy, and that copy is what reads return. The staged triple moves into the working set only when software raises an update request or releases the staging lock, and only on a period boundary. A channel that is not running takes the triple at once. This lets software retune a running waveform without ever emitting a period that mixes old and new values. The enable, clock and control registers take masked writes: each of the upper 16 data bits permits a change to the matching lower bit.

Top module: `pwm_shadow_chan`

## Requirements
- R1: A write to the enable (0x04), clock (0x08) or control (0x0C) register changes a bit in positions 15:0 only if bit (16 + position) of the same write is 1; all other bits keep their value.
- R2: After reset the output is high, the control register reads 0x0000000C (mode 0, duty level high, idle level high, unlocked), and the status (0x00), enable, clock, period (0x10) and duty (0x14) registers read 0.
- R3: In continuous mode (control bits 1:0 = 1) with the channel running, every period lasts `period` ticks and the output is at the active level during ticks 0 to duty-1 of each period and at the opposite level afterwards.
- R4: A non-zero duty equal to or larger than the period holds the output at the active level; a duty of 0 holds it at the opposite level.
- R5: Control bit 2 gives the level during the duty portion (1 = high) and control bit 3 gives the idle level (1 = high).
- R6: Writes to period and duty are read back at once but do not change the output until an update request (enable bit 2 written as 1). A running channel then takes the new period, duty and polarity together at its next period boundary. Status bit 0 reads 1 while the request waits.
- R7: While the lock (control bit 4) is 1, a waiting request is not applied. Clearing the lock applies the staged values at the next period boundary, even without a new request.
- R8: With the output enable (enable bit 1) at 0 the output is at the idle level and the counter stays at 0, and a waiting request is applied on the next clock.
- R9: In one-shot mode (control bits 1:0 = 0) the channel produces one period and then drives the idle level. Status bit 1 reads 0, and it stays stopped until the output enable goes to 0 and back to 1.
- R10: One tick lasts (scale + 1) * 2^prescale clocks, with prescale in clock bits 2:0 and scale in clock bits 12:4.
- R11: With the clock enable (enable bit 0) at 0 the counter does not advance, so the output holds its level.
- R12: Modes 2 and 3 are unsupported. In them the output is at the idle level and status bit 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe for the current address |
| addr | input | ADDR_W | Byte address of the register |
| wr_data | input | 32 | Write data; for masked registers the upper half is the mask |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The waveform is compared against a tick-by-tick model for several period and duty pairs (4/1, 6/3, 8/2 and 5/2) and for both duty levels. A mismatch in ratio, in period length or in the sense of the duty level therefore shows up at a known sample. The duty edge cases, equal to or larger than the period and zero, show whether the compare saturates correctly. A prescaled pattern, where each tick lasts four clocks, shows whether the divider counts scale and prescale in the right way. Retunes are made in a running channel, once plain and once under the lock, with the old pattern checked before release and the new one after. This tells apart an update taken at a boundary from one taken early or not at all. The one-shot run uses an idle level that differs from the inactive level, so an output that stops after one period cannot be mistaken for one that keeps running.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

   // register byte offsets
   localparam int OFF_STAT  = 'h00;
   localparam int OFF_EN    = 'h04;
   localparam int OFF_CLK   = 'h08;
   localparam int OFF_CTL   = 'h0C;
   localparam int OFF_PER   = 'h10;
   localparam int OFF_DUTY  = 'h14;

   // half-word split of masked registers
   localparam int MASK_LSB  = 16;

   // field positions that software decodes
   localparam int EN_CLK_BIT  = 0;
   localparam int EN_OUT_BIT  = 1;
   localparam int EN_REQ_BIT  = 2;
   localparam int CLK_PRE_LSB = 0;
   localparam int CLK_SCL_LSB = 4;
   localparam int CTL_MODE_LSB = 0;
   localparam int CTL_POL_LSB  = 2;
   localparam int CTL_LOCK_BIT = 4;

   typedef enum logic [1:0] {
      MODE_ONCE = 2'd0,
      MODE_LOOP = 2'd1,
      MODE_CAPT = 2'd2,
      MODE_RSVD = 2'd3
   } pwm_mode_e;

   // polarity: [0] level during duty, [1] idle level
   localparam logic [1:0] POL_RESET = 2'b11;

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
   import pwm_shadow_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 3,
   parameter int SCL_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wr_data,
   input  logic              apply,
   input  logic              running,
   output logic              clk_en,
   output logic              out_en,
   output logic [1:0]        mode,
   output logic [1:0]        pol_sh,
   output logic              lock,
   output logic [PRE_W-1:0]  pre,
   output logic [SCL_W-1:0]  scale,
   output logic [CNT_W-1:0]  per_sh,
   output logic [CNT_W-1:0]  duty_sh,
   output logic              pending,
   output logic [31:0]       rd_data
);

   logic sel_en, sel_clk, sel_ctl, sel_per, sel_duty;
   logic upd_req, lock_fall;

   always_comb begin
      sel_en   = wr_en && (addr == ADDR_W'(OFF_EN));
      sel_clk  = wr_en && (addr == ADDR_W'(OFF_CLK));
      sel_ctl  = wr_en && (addr == ADDR_W'(OFF_CTL));
      sel_per  = wr_en && (addr == ADDR_W'(OFF_PER));
      sel_duty = wr_en && (addr == ADDR_W'(OFF_DUTY));
      upd_req  = sel_en && wr_data[MASK_LSB+EN_REQ_BIT] && wr_data[EN_REQ_BIT];
      lock_fall = sel_ctl && lock && wr_data[MASK_LSB+CTL_LOCK_BIT]
                  && !wr_data[CTL_LOCK_BIT];
   end

   // enable register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_en <= 1'b0;
         out_en <= 1'b0;
      end else if (sel_en) begin
         clk_en <= (clk_en & ~wr_data[MASK_LSB+EN_CLK_BIT])
                 | (wr_data[EN_CLK_BIT] & wr_data[MASK_LSB+EN_CLK_BIT]);
         out_en <= (out_en & ~wr_data[MASK_LSB+EN_OUT_BIT])
                 | (wr_data[EN_OUT_BIT] & wr_data[MASK_LSB+EN_OUT_BIT]);
      end
   end

   // clock control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre   <= '0;
         scale <= '0;
      end else if (sel_clk) begin
         pre   <= (pre & ~wr_data[MASK_LSB+CLK_PRE_LSB +: PRE_W])
                | (wr_data[CLK_PRE_LSB +: PRE_W] & wr_data[MASK_LSB+CLK_PRE_LSB +: PRE_W]);
         scale <= (scale & ~wr_data[MASK_LSB+CLK_SCL_LSB +: SCL_W])
                | (wr_data[CLK_SCL_LSB +: SCL_W] & wr_data[MASK_LSB+CLK_SCL_LSB +: SCL_W]);
      end
   end

   // control register: mode acts at once, polarity is staged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= MODE_ONCE;
         pol_sh <= POL_RESET;
         lock   <= 1'b0;
      end else if (sel_ctl) begin
         mode   <= (mode & ~wr_data[MASK_LSB+CTL_MODE_LSB +: 2])
                 | (wr_data[CTL_MODE_LSB +: 2] & wr_data[MASK_LSB+CTL_MODE_LSB +: 2]);
         pol_sh <= (pol_sh & ~wr_data[MASK_LSB+CTL_POL_LSB +: 2])
                 | (wr_data[CTL_POL_LSB +: 2] & wr_data[MASK_LSB+CTL_POL_LSB +: 2]);
         lock   <= (lock & ~wr_data[MASK_LSB+CTL_LOCK_BIT])
                 | (wr_data[CTL_LOCK_BIT] & wr_data[MASK_LSB+CTL_LOCK_BIT]);
      end
   end

   // staged period and duty, plain full-word writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_sh  <= '0;
         duty_sh <= '0;
      end else begin
         if (sel_per)  per_sh  <= wr_data[CNT_W-1:0];
         if (sel_duty) duty_sh <= wr_data[CNT_W-1:0];
      end
   end

   // waiting-update flag: a new request wins over a same-cycle apply
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pending <= 1'b0;
      else if (upd_req || lock_fall) pending <= 1'b1;
      else if (apply)               pending <= 1'b0;
   end

   always_comb begin
      rd_data = '0;
      case (addr)
         ADDR_W'(OFF_STAT): begin
            rd_data[0] = pending;
            rd_data[1] = running;
         end
         ADDR_W'(OFF_EN): begin
            rd_data[EN_CLK_BIT] = clk_en;
            rd_data[EN_OUT_BIT] = out_en;
         end
         ADDR_W'(OFF_CLK): begin
            rd_data[CLK_PRE_LSB +: PRE_W] = pre;
            rd_data[CLK_SCL_LSB +: SCL_W] = scale;
         end
         ADDR_W'(OFF_CTL): begin
            rd_data[CTL_MODE_LSB +: 2] = mode;
            rd_data[CTL_POL_LSB +: 2]  = pol_sh;
            rd_data[CTL_LOCK_BIT]      = lock;
         end
         ADDR_W'(OFF_PER):  rd_data = 32'(per_sh);
         ADDR_W'(OFF_DUTY): rd_data = 32'(duty_sh);
         default:           rd_data = '0;
      endcase
   end

endmodule

// File: rtl/pwm_shadow_tick.sv
module pwm_shadow_tick #(
   parameter int PRE_W = 3,
   parameter int SCL_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre,
   input  logic [SCL_W-1:0] scale,
   output logic             tick
);

   // widest divisor is 2^SCL_W * 2^(2^PRE_W - 1)
   localparam int DIV_W = SCL_W + (1 << PRE_W);

   logic [DIV_W-1:0] span, lim, pcnt;

   always_comb begin
      span = (DIV_W'(scale) + DIV_W'(1)) << pre;
      lim  = span - DIV_W'(1);
      tick = run && (pcnt == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pcnt <= '0;
      else if (!run) pcnt <= '0;
      else if (tick) pcnt <= '0;
      else           pcnt <= pcnt + DIV_W'(1);
   end

endmodule

// File: rtl/pwm_shadow_core.sv
module pwm_shadow_core
   import pwm_shadow_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter bit ONESHOT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             out_en,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] per_sh,
   input  logic [CNT_W-1:0] duty_sh,
   input  logic [1:0]       pol_sh,
   input  logic             pending,
   input  logic             lock,
   output logic             active_run,
   output logic             wrap,
   output logic             apply,
   output logic             done,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] act_period,
   output logic [CNT_W-1:0] act_duty,
   output logic [1:0]       act_pol,
   output logic             pwm_out
);

   logic [CNT_W:0] cnt_inc;

   always_comb begin
      active_run = out_en && !mode[1] && !done;
      cnt_inc    = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
      wrap       = tick && (cnt_inc >= {1'b0, act_period});
      apply      = pending && !lock && (wrap || !active_run);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!active_run) cnt <= '0;
      else if (wrap)        cnt <= '0;
      else if (tick)        cnt <= cnt_inc[CNT_W-1:0];
   end

   // working set, loaded as one triple
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_period <= '0;
         act_duty   <= '0;
         act_pol    <= POL_RESET;
      end else if (apply) begin
         act_period <= per_sh;
         act_duty   <= duty_sh;
         act_pol    <= pol_sh;
      end
   end

   generate
      if (ONESHOT_EN) begin : g_once
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       done <= 1'b0;
            else if (!out_en) done <= 1'b0;
            else if (active_run && wrap && (mode == MODE_ONCE)) done <= 1'b1;
         end
      end else begin : g_no_once
         assign done = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!active_run)          pwm_out = act_pol[1];
      else if (cnt < act_duty)  pwm_out = act_pol[0];
      else                      pwm_out = !act_pol[0];
   end

endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
   import pwm_shadow_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int CNT_W      = 32,
   parameter int PRE_W      = 3,
   parameter int SCL_W      = 9,
   parameter bit ONESHOT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wr_data,
   output logic [31:0]       rd_data,
   output logic              pwm_out
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 2..32");
      end
      if (PRE_W < 1 || PRE_W > CLK_SCL_LSB - CLK_PRE_LSB) begin : g_bad_pre
         $error("PRE_W must lie in 1..4");
      end
      if (SCL_W < 1 || CLK_SCL_LSB + SCL_W > MASK_LSB) begin : g_bad_scl
         $error("scale field must fit below the mask half");
      end
      if ((1 << ADDR_W) <= OFF_DUTY) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic             clk_en, out_en, lock, pending, apply;
   logic             active_run, wrap, done, tick;
   logic [1:0]       mode, pol_sh, act_pol;
   logic [PRE_W-1:0] pre;
   logic [SCL_W-1:0] scale;
   logic [CNT_W-1:0] per_sh, duty_sh, cnt, act_period, act_duty;

   pwm_shadow_regs #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .SCL_W(SCL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .apply(apply), .running(active_run),
      .clk_en(clk_en), .out_en(out_en), .mode(mode), .pol_sh(pol_sh), .lock(lock),
      .pre(pre), .scale(scale), .per_sh(per_sh), .duty_sh(duty_sh),
      .pending(pending), .rd_data(rd_data)
   );

   pwm_shadow_tick #(
      .PRE_W(PRE_W), .SCL_W(SCL_W)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .run(active_run && clk_en),
      .pre(pre), .scale(scale), .tick(tick)
   );

   pwm_shadow_core #(
      .CNT_W(CNT_W), .ONESHOT_EN(ONESHOT_EN)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .out_en(out_en), .mode(mode),
      .per_sh(per_sh), .duty_sh(duty_sh), .pol_sh(pol_sh),
      .pending(pending), .lock(lock),
      .active_run(active_run), .wrap(wrap), .apply(apply), .done(done),
      .cnt(cnt), .act_period(act_period), .act_duty(act_duty), .act_pol(act_pol),
      .pwm_out(pwm_out)
   );

endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwm_out,
   input logic             out_en,
   input logic [1:0]       mode,
   input logic             lock,
   input logic             active_run,
   input logic             wrap,
   input logic             done,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] act_period,
   input logic [CNT_W-1:0] act_duty,
   input logic [1:0]       act_pol
);

   // R8
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> pwm_out == act_pol[1]);

   // R8
   off_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |=> cnt == '0);

   // R6
   mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_run && !wrap) |=> ($stable(act_period) && $stable(act_duty) && $stable(act_pol)));

   // R7
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> ($stable(act_period) && $stable(act_duty) && $stable(act_pol)));

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_run && act_period != '0) |-> cnt < act_period);

   // R4
   full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_run && act_duty != '0 && act_duty >= act_period) |-> pwm_out == act_pol[0]);

   // R4
   zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_run && act_duty == '0) |-> pwm_out == !act_pol[0]);

   // R9
   once_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_run && wrap && mode == 2'd0) |=> done);

   // R9
   once_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && done) |-> pwm_out == act_pol[1]);

   // R12
   capt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode[1] |-> (pwm_out == act_pol[1] && !active_run));

endmodule

bind pwm_shadow_chan pwm_shadow_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .out_en(out_en), .mode(mode),
   .lock(lock), .active_run(active_run), .wrap(wrap), .done(done), .cnt(cnt),
   .act_period(act_period), .act_duty(act_duty), .act_pol(act_pol)
);

// File: tb/sim_pwm_shadow_chan.sv
module sim_pwm_shadow_chan;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;

   localparam logic [AW-1:0] A_STAT = 5'h00;
   localparam logic [AW-1:0] A_EN   = 5'h04;
   localparam logic [AW-1:0] A_CLK  = 5'h08;
   localparam logic [AW-1:0] A_CTL  = 5'h0C;
   localparam logic [AW-1:0] A_PER  = 5'h10;
   localparam logic [AW-1:0] A_DUTY = 5'h14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   rd_data;
   logic          pwm_out;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   pwm_shadow_chan #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      logic [31:0] v;
      rd(a, v);
      check(v === exp, tag, v, exp);
   endtask

   task automatic request();
      wr(A_EN, 32'h0004_0004);
   endtask

   task automatic wait_applied(input string tag);
      logic [31:0] v;
      bit got = 1'b0;
      for (int i = 0; i < 400; i++) begin
         rd(A_STAT, v);
         if (!v[0]) begin
            got = 1'b1;
            break;
         end
         @(negedge clk);
      end
      check(got, tag, {31'b0, got}, 32'h1);
   endtask

   // compares n samples at negedges: sample k is active when ((k/dv)%p) < d
   task automatic check_wave(input int p, input int d, input int dv, input logic act,
                             input int n, input bit align, input string tag);
      int errs = 0;
      logic prev;
      if (align) begin
         prev = pwm_out;
         for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (prev !== act && pwm_out === act) break;
            prev = pwm_out;
         end
      end
      for (int k = 0; k < n; k++) begin
         logic e;
         e = (((k / dv) % p) < d) ? act : ~act;
         if (pwm_out !== e) begin
            errs++;
            n_fail++;
            $display("FAIL %s sample %0d actual=%0b expected=%0b", tag, k, pwm_out, e);
         end
         n_chk++;
         @(negedge clk);
      end
   endtask

   task automatic check_const(input logic lvl, input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         check(pwm_out === lvl, tag, {31'b0, pwm_out}, {31'b0, lvl});
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(pwm_out === 1'b1, "R2 output idle high", {31'b0, pwm_out}, 32'h1);
      rd_chk(A_CTL,  32'h0000_000C, "R2 control reset");
      rd_chk(A_STAT, 32'h0, "R2 status reset");
      rd_chk(A_EN,   32'h0, "R2 enable reset");
      rd_chk(A_CLK,  32'h0, "R2 clock reset");
      rd_chk(A_PER,  32'h0, "R2 period reset");
      rd_chk(A_DUTY, 32'h0, "R2 duty reset");
   endtask

   task automatic t_mask();
      wr(A_EN, 32'h0000_0003);
      rd_chk(A_EN, 32'h0, "R1 enable unmasked write ignored");
      wr(A_CTL, 32'h0003_0001);
      rd_chk(A_CTL, 32'h0000_000D, "R1 control mode-only write keeps polarity");
      wr(A_CLK, 32'h0001_0007);
      rd_chk(A_CLK, 32'h0000_0001, "R1 clock partial mask");
      wr(A_CLK, 32'h1FF7_0000);
      rd_chk(A_CLK, 32'h0, "R1 clock cleared");
      check(pwm_out === 1'b1, "R1 output unchanged", {31'b0, pwm_out}, 32'h1);
   endtask

   task automatic t_continuous();
      wr(A_PER, 32'd4);
      wr(A_DUTY, 32'd1);
      request();
      @(negedge clk);
      rd_chk(A_STAT, 32'h0, "R8 idle channel applies at once");
      wr(A_EN, 32'h0003_0003);
      check_wave(4, 1, 1, 1'b1, 12, 1'b0, "R3 period 4 duty 1");
      rd_chk(A_STAT, 32'h2, "R3 status running");
   endtask

   task automatic t_shadow();
      logic [31:0] v;
      wr(A_PER, 32'd6);
      wr(A_DUTY, 32'd3);
      rd_chk(A_PER, 32'd6, "R6 period reads staged value");
      rd_chk(A_DUTY, 32'd3, "R6 duty reads staged value");
      check_wave(4, 1, 1, 1'b1, 8, 1'b1, "R6 old pattern kept without request");
      request();
      rd(A_STAT, v);
      check(v[0] === 1'b1, "R6 pending after request", v, 32'h3);
      wait_applied("R6 request applied");
      check_wave(6, 3, 1, 1'b1, 12, 1'b1, "R6 new period 6 duty 3");
   endtask

   task automatic t_lock();
      logic [31:0] v;
      wr(A_CTL, 32'h0010_0010);
      wr(A_PER, 32'd8);
      wr(A_DUTY, 32'd2);
      request();
      repeat (20) @(negedge clk);
      rd(A_STAT, v);
      check(v[0] === 1'b1, "R7 request held by lock", v, 32'h3);
      check_wave(6, 3, 1, 1'b1, 12, 1'b1, "R7 locked pattern unchanged");
      wr(A_CTL, 32'h0010_0000);
      wait_applied("R7 release applies");
      check_wave(8, 2, 1, 1'b1, 16, 1'b1, "R7 new period 8 duty 2");
   endtask

   task automatic t_polarity();
      wr(A_CTL, 32'h000C_0000);
      request();
      wait_applied("R5 polarity applied");
      check_wave(8, 2, 1, 1'b0, 16, 1'b1, "R5 duty portion low");
      wr(A_EN, 32'h0002_0000);
      check_const(1'b0, 4, "R5 idle level low");
      wr(A_CTL, 32'h000C_000C);
      request();
      wait_applied("R5 polarity restored");
      check_const(1'b1, 4, "R8 idle level high when off");
   endtask

   task automatic t_duty_edges();
      wr(A_PER, 32'd4);
      wr(A_DUTY, 32'd6);
      request();
      wait_applied("R4 wide duty applied");
      wr(A_EN, 32'h0002_0002);
      check_const(1'b1, 12, "R4 duty above period stays active");
      wr(A_DUTY, 32'd0);
      request();
      wait_applied("R4 zero duty applied");
      check_const(1'b0, 12, "R4 zero duty stays inactive");
   endtask

   task automatic t_freeze();
      logic v0;
      wr(A_DUTY, 32'd1);
      request();
      wait_applied("R11 setup");
      check_wave(4, 1, 1, 1'b1, 4, 1'b1, "R11 running before freeze");
      wr(A_EN, 32'h0001_0000);
      v0 = pwm_out;
      check_const(v0, 12, "R11 output held with clock enable low");
      wr(A_EN, 32'h0001_0001);
      check_wave(4, 1, 1, 1'b1, 8, 1'b1, "R11 resumes");
   endtask

   task automatic t_capture();
      wr(A_CTL, 32'h0003_0002);
      check_const(1'b1, 8, "R12 mode 2 drives idle");
      rd_chk(A_STAT, 32'h0, "R12 mode 2 not running");
      wr(A_CTL, 32'h0003_0001);
   endtask

   task automatic t_divider();
      wr(A_EN, 32'h0002_0000);
      wr(A_CLK, 32'h1FF7_0011);
      wr(A_PER, 32'd2);
      wr(A_DUTY, 32'd1);
      request();
      wait_applied("R10 setup");
      wr(A_EN, 32'h0002_0002);
      check_wave(2, 1, 4, 1'b1, 16, 1'b0, "R10 tick every 4 clocks");
      wr(A_EN, 32'h0002_0000);
      wr(A_CLK, 32'h1FF7_0000);
   endtask

   task automatic t_oneshot();
      wr(A_CTL, 32'h0003_0000);
      wr(A_PER, 32'd5);
      wr(A_DUTY, 32'd2);
      request();
      wait_applied("R9 setup");
      for (int run = 0; run < 2; run++) begin
         wr(A_EN, 32'h0002_0002);
         for (int k = 0; k < 14; k++) begin
            logic e;
            e = (k < 2) ? 1'b1 : ((k < 5) ? 1'b0 : 1'b1);
            check(pwm_out === e, "R9 one period then idle", {31'b0, pwm_out}, {31'b0, e});
            @(negedge clk);
         end
         rd_chk(A_STAT, 32'h0, "R9 stopped after one period");
         wr(A_EN, 32'h0002_0000);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mask();
      t_continuous();
      t_shadow();
      t_lock();
      t_polarity();
      t_duty_edges();
      t_freeze();
      t_capture();
      t_divider();
      t_oneshot();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule